// File: doc/BRIEF.md
# Watermark Write-Drain Mode Controller

This block decides, once per clock, whether one memory channel's command scheduler should serve its read queue or its write queue. It watches how full the write queue is against two watermarks set below its capacity. Above the high watermark writes must drain. An empty write queue returns the channel to reads.

Between the watermarks the choice follows row locality. The controller stays on whichever direction still has an issuable row hit, so the shared data bus is turned around as rarely as possible. When the read queue runs dry, the switch to writes is held off for a short wait, in case a read arrives. That wait is allowed only while recent column traffic is light. A density monitor counts issued column commands over a fixed window and enables or disables the wait at the end of each window.

The block also keeps running statistics:
- cycles spent above the high watermark;
- cycles spent below the low watermark;
- column-to-column direction changes.

The controller is a two-state machine with the states READ_DRAIN and WRITE_DRAIN. Its transitions are:
- **high-watermark entry**: occupancy above the high watermark moves to WRITE_DRAIN;
- **empty exit**: an empty write queue moves to READ_DRAIN;
- **low-watermark clear**: occupancy below the low watermark makes READ_DRAIN the prior state for the locality rules;
- **locality hold / locality switch**: with reads pending, the state follows row-hit availability;
- **delay wait**: the controller holds READ_DRAIN while the idle-read counter counts;
- **delay expiry**: the controller enters WRITE_DRAIN once the counter reaches its limit;
- **immediate drain**: with the wait disabled, an idle read queue enters WRITE_DRAIN at once.

Top module: `dm_drain_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `drain_wr` is 0 (read drain), `delay_en` is 0, all six statistics outputs are 0, and the last column direction is taken as read.
- R2: When `wr_len` exceeds the high watermark (WQ_CAP − 2), `drain_wr` is 1 after the next rising edge, whatever the other inputs are.
- R3: When `wr_len` is 0 and the high-watermark rule does not apply, `drain_wr` is 0 after the next rising edge.
- R4: With reads pending (`rd_len` ≠ 0), 0 < `wr_len` ≤ high watermark and a prior state of write drain, the next state is write drain if `wr_hit` is 1, read drain if only `rd_hit` is 1, and write drain if neither is 1.
- R5: Under the same conditions with a prior state of read drain, the next state is read drain if `rd_hit` is 1, write drain if only `wr_hit` is 1, and read drain if neither is 1. Pending reads clear the idle-read counter.
- R6: For the rules in R4 and R5, the prior state is read drain whenever `wr_len` is below the low watermark (WQ_CAP − 28), whatever the current state is.
- R7: With `rd_len` = 0, 0 < `wr_len` ≤ high watermark and `delay_en` = 1, the controller stays in read drain and increments the idle-read counter while the counter is below DELAY_MAX (2). When the counter has reached DELAY_MAX, it enters write drain.
- R8: On delay expiry the counter is cleared only if `wr_len` is below the low watermark. This gives a repeating read, read, write pattern. Otherwise the counter stays at its limit and write drain continues every cycle.
- R9: With `rd_len` = 0, 0 < `wr_len` ≤ high watermark and `delay_en` = 0, `drain_wr` is 1 after the next edge.
- R10: `col_issued` pulses are counted over consecutive windows of DENS_PERIOD cycles starting at reset. At the last cycle of each window, `delay_en` becomes 1 if the window's count, including that cycle, is at most DENS_THRESH, and 0 otherwise. `delay_en` changes at no other time.
- R11: `cyc_above_hi` counts cycles with `wr_len` above the high watermark. `cyc_below_lo` counts cycles with `wr_len` below the low watermark. Each count includes the cycle just sampled.
- R12: Each `col_issued` pulse raises exactly one of `n_rd_rd`, `n_rd_wr`, `n_wr_rd` and `n_wr_wr`, chosen by the previous column's direction and the current one (`col_is_write` = 1 means write). The current direction then becomes the previous one. All statistics are STAT_W bits wide and wrap without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_len | input | $clog2(RQ_CAP+1) | Current read-queue occupancy |
| wr_len | input | $clog2(WQ_CAP+1) | Current write-queue occupancy |
| rd_hit | input | 1 | An issuable row-hit read exists this cycle |
| wr_hit | input | 1 | An issuable row-hit write exists this cycle |
| col_issued | input | 1 | A column command was issued this cycle |
| col_is_write | input | 1 | Direction of that column command, 1 = write |
| drain_wr | output | 1 | Mode: 1 = write drain, 0 = read drain |
| delay_en | output | 1 | Idle-read delay currently permitted |
| cyc_above_hi | output | STAT_W | Cycles above the high watermark |
| cyc_below_lo | output | STAT_W | Cycles below the low watermark |
| n_rd_rd | output | STAT_W | Read followed by read |
| n_rd_wr | output | STAT_W | Read followed by write |
| n_wr_rd | output | STAT_W | Write followed by read |
| n_wr_wr | output | STAT_W | Write followed by write |

## Verification
Every result of this block is due one rising edge after its inputs are sampled. This holds for the mode bit, for `delay_en` at the end of a window, and for each statistics increment. The bench applies each stimulus just after a falling edge and lets one rising edge pass. It then compares all outputs at the following falling edge with a cycle model built from the requirements, so no comparison reads a value from the same edge that produced it. Directed sequences check the delay-expiry patterns against hand-derived mode sequences. An exhaustive pass covers each prior state, a set of watermark-boundary occupancies, empty and non-empty read queues, and every hit combination.

// File: rtl/dm_pkg.sv
package dm_pkg;

    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } drain_mode_e;

    localparam int IDX_ABOVE  = 0;
    localparam int IDX_BELOW  = 1;
    localparam int IDX_RD_RD  = 2;
    localparam int IDX_RD_WR  = 3;
    localparam int IDX_WR_RD  = 4;
    localparam int IDX_WR_WR  = 5;
    localparam int NUM_STATS  = 6;

endpackage

// File: rtl/dm_mode_fsm.sv
module dm_mode_fsm
    import dm_pkg::*;
#(
    parameter int LW        = 7,
    parameter int HI_LVL    = 62,
    parameter int LO_LVL    = 36,
    parameter int DELAY_MAX = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] wr_len,
    input  logic          rd_empty,
    input  logic          rd_hit,
    input  logic          wr_hit,
    input  logic          delay_en,
    output logic          drain_wr
);

    localparam int             DW      = (DELAY_MAX < 1) ? 1 : $clog2(DELAY_MAX + 1);
    localparam logic [DW-1:0]  DLY_LIM = DW'(DELAY_MAX);
    localparam logic [LW-1:0]  HI_V    = LW'(HI_LVL);
    localparam logic [LW-1:0]  LO_V    = LW'(LO_LVL);

    drain_mode_e   st_q, st_d, st_prior;
    logic [DW-1:0] dly_q, dly_d;
    logic          above, below, wq_empty, mid_band;

    always_comb begin
        above    = (wr_len > HI_V);
        below    = (wr_len < LO_V);
        wq_empty = (wr_len == '0);
        mid_band = !above && !wq_empty;
    end

    // Next-state decision
    always_comb begin
        st_prior = below ? MODE_READ : st_q;
        st_d     = st_prior;
        dly_d    = dly_q;
        if (above) begin
            st_d = MODE_WRITE;
        end else if (wq_empty) begin
            st_d = MODE_READ;
        end else if (rd_empty) begin
            if (!delay_en) begin
                st_d = MODE_WRITE;
            end else if (dly_q < DLY_LIM) begin
                st_d  = MODE_READ;
                dly_d = dly_q + DW'(1);
            end else begin
                st_d = MODE_WRITE;
                if (below) begin
                    dly_d = '0;
                end
            end
        end else begin
            dly_d = '0;
            unique case (st_prior)
                MODE_WRITE: st_d = (wr_hit || !rd_hit) ? MODE_WRITE : MODE_READ;
                MODE_READ:  st_d = (!rd_hit && wr_hit) ? MODE_WRITE : MODE_READ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MODE_READ;
            dly_q <= '0;
        end else begin
            st_q  <= st_d;
            dly_q <= dly_d;
        end
    end

    // Outputs
    always_comb begin
        drain_wr = (st_q == MODE_WRITE);
    end

    p_high_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len > HI_V) |=> drain_wr);

    p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len == '0) |=> !drain_wr);

    p_reads_clear_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_empty && mid_band) |=> (dly_q == '0));

    p_wait_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && delay_en && mid_band && (dly_q < DLY_LIM))
        |=> (!drain_wr && (dly_q == $past(dly_q) + DW'(1))));

    p_expiry_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && delay_en && mid_band && (dly_q == DLY_LIM) && !below)
        |=> (drain_wr && (dly_q == DLY_LIM)));

    p_nodelay_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && !delay_en && mid_band) |=> drain_wr);

    p_lo_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_empty && mid_band && below && rd_hit) |=> !drain_wr);

endmodule

// File: rtl/dm_density.sv
module dm_density #(
    parameter int PERIOD = 1000,
    parameter int THRESH = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_issued,
    output logic delay_en
);

    localparam int PW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] per_q;
    logic [CW-1:0] cnt_q, sum;
    logic          tick;

    always_comb begin
        tick = (per_q == LAST);
        sum  = cnt_q + CW'(col_issued);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q    <= '0;
            cnt_q    <= '0;
            delay_en <= 1'b0;
        end else if (tick) begin
            per_q    <= '0;
            cnt_q    <= '0;
            delay_en <= (32'(sum) <= 32'(THRESH));
        end else begin
            per_q    <= per_q + PW'(1);
            cnt_q    <= sum;
        end
    end

    p_enable_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(delay_en));

    p_window_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (per_q == '0 && cnt_q == '0));

endmodule

// File: rtl/dm_stat_ctr.sv
module dm_stat_ctr #(
    parameter int SW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [SW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + SW'(1);
        end
    end

endmodule

// File: rtl/dm_stats.sv
module dm_stats
    import dm_pkg::*;
#(
    parameter int LW     = 7,
    parameter int HI_LVL = 62,
    parameter int LO_LVL = 36,
    parameter int SW     = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LW-1:0]                 wr_len,
    input  logic                          col_issued,
    input  logic                          col_is_write,
    output logic [NUM_STATS-1:0][SW-1:0]  counts
);

    logic [NUM_STATS-1:0] inc;
    logic                 last_wr_q;
    logic [SW-1:0]        tr_sum;

    always_comb begin
        inc            = '0;
        inc[IDX_ABOVE] = (wr_len > LW'(HI_LVL));
        inc[IDX_BELOW] = (wr_len < LW'(LO_LVL));
        inc[IDX_RD_RD] = col_issued && !last_wr_q && !col_is_write;
        inc[IDX_RD_WR] = col_issued && !last_wr_q &&  col_is_write;
        inc[IDX_WR_RD] = col_issued &&  last_wr_q && !col_is_write;
        inc[IDX_WR_WR] = col_issued &&  last_wr_q &&  col_is_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr_q <= 1'b0;
        end else if (col_issued) begin
            last_wr_q <= col_is_write;
        end
    end

    for (genvar k = 0; k < NUM_STATS; k++) begin : g_ctr
        dm_stat_ctr #(.SW(SW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[k]),
            .count (counts[k])
        );
    end

    always_comb begin
        tr_sum = counts[IDX_RD_RD] + counts[IDX_RD_WR]
               + counts[IDX_WR_RD] + counts[IDX_WR_WR];
    end

    p_trans_sum_r12: assert property (@(posedge clk) disable iff (!rst_n)
        col_issued |=> (tr_sum == $past(tr_sum) + SW'(1)));

    p_trans_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !col_issued |=> $stable(tr_sum));

    p_above_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len > LW'(HI_LVL))
        |=> (counts[IDX_ABOVE] == $past(counts[IDX_ABOVE]) + SW'(1)));

    p_below_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len >= LW'(LO_LVL)) |=> $stable(counts[IDX_BELOW]));

endmodule

// File: rtl/dm_drain_ctrl.sv
module dm_drain_ctrl
    import dm_pkg::*;
#(
    parameter int WQ_CAP      = 64,
    parameter int RQ_CAP      = 64,
    parameter int HI_GAP      = 2,
    parameter int LO_GAP      = 28,
    parameter int DELAY_MAX   = 2,
    parameter int DENS_PERIOD = 1000,
    parameter int DENS_THRESH = 20,
    parameter int STAT_W      = 64,
    localparam int LW         = $clog2(WQ_CAP + 1),
    localparam int RLW        = $clog2(RQ_CAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RLW-1:0]    rd_len,
    input  logic [LW-1:0]     wr_len,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic              col_issued,
    input  logic              col_is_write,
    output logic              drain_wr,
    output logic              delay_en,
    output logic [STAT_W-1:0] cyc_above_hi,
    output logic [STAT_W-1:0] cyc_below_lo,
    output logic [STAT_W-1:0] n_rd_rd,
    output logic [STAT_W-1:0] n_rd_wr,
    output logic [STAT_W-1:0] n_wr_rd,
    output logic [STAT_W-1:0] n_wr_wr
);

    localparam int HI_LVL = WQ_CAP - HI_GAP;
    localparam int LO_LVL = WQ_CAP - LO_GAP;

    logic                             rd_empty;
    logic [NUM_STATS-1:0][STAT_W-1:0] counts;

    always_comb begin
        rd_empty = (rd_len == '0);
    end

    dm_density #(
        .PERIOD (DENS_PERIOD),
        .THRESH (DENS_THRESH)
    ) u_density (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_issued (col_issued),
        .delay_en   (delay_en)
    );

    dm_mode_fsm #(
        .LW        (LW),
        .HI_LVL    (HI_LVL),
        .LO_LVL    (LO_LVL),
        .DELAY_MAX (DELAY_MAX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_len   (wr_len),
        .rd_empty (rd_empty),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit),
        .delay_en (delay_en),
        .drain_wr (drain_wr)
    );

    dm_stats #(
        .LW     (LW),
        .HI_LVL (HI_LVL),
        .LO_LVL (LO_LVL),
        .SW     (STAT_W)
    ) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_len       (wr_len),
        .col_issued   (col_issued),
        .col_is_write (col_is_write),
        .counts       (counts)
    );

    always_comb begin
        cyc_above_hi = counts[IDX_ABOVE];
        cyc_below_lo = counts[IDX_BELOW];
        n_rd_rd      = counts[IDX_RD_RD];
        n_rd_wr      = counts[IDX_RD_WR];
        n_wr_rd      = counts[IDX_WR_RD];
        n_wr_wr      = counts[IDX_WR_WR];
    end

    p_reset_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !drain_wr);

endmodule

// File: tb/test_dm_drain_ctrl.sv
module test_dm_drain_ctrl;

    localparam int WQ   = 32;
    localparam int RQ   = 8;
    localparam int PER  = 16;
    localparam int TH   = 3;
    localparam int DMAX = 2;
    localparam int HI   = WQ - 2;
    localparam int LO   = WQ - 28;
    localparam int LW   = $clog2(WQ + 1);
    localparam int RLW  = $clog2(RQ + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [RLW-1:0] rd_len = '0;
    logic [LW-1:0]  wr_len = '0;
    logic           rd_hit = 1'b0, wr_hit = 1'b0, col_issued = 1'b0, col_is_write = 1'b0;
    logic           drain_wr, delay_en;
    logic [63:0]    cyc_above_hi, cyc_below_lo, n_rd_rd, n_rd_wr, n_wr_rd, n_wr_wr;

    always #10 clk = ~clk;

    dm_drain_ctrl #(
        .WQ_CAP(WQ), .RQ_CAP(RQ), .HI_GAP(2), .LO_GAP(28), .DELAY_MAX(DMAX),
        .DENS_PERIOD(PER), .DENS_THRESH(TH), .STAT_W(64)
    ) i_dm_drain_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_len(rd_len), .wr_len(wr_len),
        .rd_hit(rd_hit), .wr_hit(wr_hit), .col_issued(col_issued),
        .col_is_write(col_is_write), .drain_wr(drain_wr), .delay_en(delay_en),
        .cyc_above_hi(cyc_above_hi), .cyc_below_lo(cyc_below_lo),
        .n_rd_rd(n_rd_rd), .n_rd_wr(n_rd_wr), .n_wr_rd(n_wr_rd), .n_wr_wr(n_wr_wr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Cycle model built from the requirements
    bit              m_mode = 0, m_den = 0, m_last = 0;
    int              m_cnt = 0, m_dens = 0, m_per = 0;
    longint unsigned m_st [6] = '{0, 0, 0, 0, 0, 0};
    string           m_tag = "R1";
    logic [31:0]     lf = 32'h1ACE_B00C;

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(int wl, int rl, bit rh, bit wh, bit ci, bit cw);
        bit below, above, prior;
        below = (wl < LO);
        above = (wl > HI);
        prior = below ? 1'b0 : m_mode;
        if (above) begin
            m_mode = 1; m_tag = "R2";
        end else if (wl == 0) begin
            m_mode = 0; m_tag = "R3";
        end else if (rl == 0) begin
            if (!m_den) begin
                m_mode = 1; m_tag = "R9";
            end else if (m_cnt < DMAX) begin
                m_mode = 0; m_cnt++; m_tag = "R7";
            end else begin
                m_mode = 1; m_tag = "R8";
                if (below) m_cnt = 0;
            end
        end else begin
            m_cnt = 0;
            if (prior) m_mode = wh || !rh;
            else       m_mode = !rh && wh;
            m_tag = below ? "R6" : (prior ? "R4" : "R5");
        end
        if (above) m_st[0]++;
        if (below) m_st[1]++;
        if (ci) begin
            m_st[2 + 2 * int'(m_last) + int'(cw)]++;
            m_last = cw;
        end
        if (m_per == PER - 1) begin
            m_den  = ((m_dens + int'(ci)) <= TH);
            m_dens = 0;
            m_per  = 0;
        end else begin
            m_per++;
            m_dens += int'(ci);
        end
    endtask

    task automatic compare_all();
        chk(m_tag, longint'(drain_wr), longint'(m_mode));
        chk("R10 delay_en", longint'(delay_en), longint'(m_den));
        chk("R11 above", cyc_above_hi, m_st[0]);
        chk("R11 below", cyc_below_lo, m_st[1]);
        chk("R12 rd_rd", n_rd_rd, m_st[2]);
        chk("R12 rd_wr", n_rd_wr, m_st[3]);
        chk("R12 wr_rd", n_wr_rd, m_st[4]);
        chk("R12 wr_wr", n_wr_wr, m_st[5]);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic cyc(int wl, int rl, bit rh, bit wh, bit ci, bit cw);
        wr_len = LW'(wl); rd_len = RLW'(rl);
        rd_hit = rh; wr_hit = wh; col_issued = ci; col_is_write = cw;
        @(posedge clk);
        model_step(wl, rl, rh, wh, ci, cw);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [31:0] nxt(logic [31:0] v);
        logic [31:0] x;
        x = v ^ (v << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    initial begin
        int wl_set [10] = '{0, 1, 3, 4, 5, 16, 29, 30, 31, 32};
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 drain_wr", longint'(drain_wr), 0);
        chk("R1 delay_en", longint'(delay_en), 0);
        chk("R1 stats", cyc_above_hi | cyc_below_lo | n_rd_rd | n_rd_wr | n_wr_rd | n_wr_wr, 0);
        rst_n = 1'b1;

        // R9: delay disabled in first window, dense traffic keeps it off
        for (int k = 0; k < 8; k++) cyc(5, 0, 0, 0, 1, k[0]);
        chk("R9 immediate write", longint'(drain_wr), 1);

        // Quiet until the wait is enabled (R10)
        for (int k = 0; k < 3 * PER && !m_den; k++) cyc(0, 0, 0, 0, 0, 0);
        chk("R10 enabled after quiet window", longint'(delay_en), 1);

        // R8: below low watermark -> read, read, write repeating
        cyc(2, 1, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            cyc(2, 0, 0, 0, 0, 0);
            chk("R8 low pattern", longint'(drain_wr), longint'(k % 3 == 2));
        end
        // R8: at or above low watermark -> read, read, then writes back to back
        cyc(10, 1, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            cyc(10, 0, 0, 0, 0, 0);
            chk("R8 mid pattern", longint'(drain_wr), longint'(k >= 2));
        end

        // Exhaustive: prior state x occupancy x read queue x hits (R2-R7)
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 10; w++)
                for (int r = 0; r < 2; r++)
                    for (int h = 0; h < 4; h++) begin
                        cyc(p ? 31 : 0, 3, 0, 0, 0, 0);
                        cyc(wl_set[w], r * 5, h[0], h[1], 0, 0);
                    end

        // Pseudo-random sweep with alternating traffic density (R10-R12)
        for (int k = 0; k < 4000; k++) begin
            int wl, rl;
            bit ci;
            lf = nxt(lf);
            wl = wl_set[int'(lf[3:0]) % 10];
            rl = (lf[5:4] == 2'b00) ? 0 : int'(lf[9:6]) % (RQ + 1);
            ci = ((k / 64) % 2 == 1) ? lf[12] : (lf[15:13] == 3'b000);
            cyc(wl, rl, lf[10], lf[11], ci, lf[16]);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule